// File: doc/BRIEF.md
# Grouped Match-Channel Timer Bank

This block holds eight match channels, numbered 4 to 11, each with a match word, a counter and a control word. The counters do not run from the bus clock. Each one advances on single-cycle rate strobes that arrive from outside on `rate_stb`. The control word of each channel sets four things: which strobe drives its counter, whether the channel compares against its own counter or against the counter of its group leader, whether the counter is zeroed on a match, and whether the channel fires again after its first event.

Channels fall into three groups. Channels 4 to 7 follow channel 4, channel 9 follows channel 8, and channel 11 follows channel 10. A match event sets a status bit if that channel's enable bit is set. All eight status bits are ORed onto one interrupt line, and software clears them by writing ones. For channels 9 and 11, a read of the counter can copy the leader's counter into a snapshot word. Software then reads that word to get the leader's value at the moment of the read.

The bus is a simple strobe interface with byte addresses. Read data is registered and appears one clock after the read strobe.

Top module: `match_timer_bank`

## Requirements
- R1: After reset, all match, counter and control words read 0, the enable, status and snapshot words read 0, `irq_o` is low, and no counter advances on any strobe.
- R2: Control bits [2:0] pick the rate. Code k in 1..5 advances the counter by exactly one per cycle in which `rate_stb[k-1]` is high. Codes 0, 6 and 7 hold the counter.
- R3: Channels 4, 8 and 10 always count at their own rate. Channels 5–7, 9 and 11 with control bit 7 = 0 compare against the counter of channel 4, 8 or 10 respectively, and their own counter holds. With bit 7 = 1 they count and compare on their own counter.
- R4: The control word of channels 4–7 keeps only bits [7:0]. For channels 8–11 it keeps bits [9:0], and bit 8 = 1 holds that channel's counter.
- R5: A match is the cycle in which the compared counter advances to a value equal to the match word. On a match of channel n, status bit n is set only if enable bit n is set.
- R6: With control bit 3 = 1, a match loads 0 into the channel's own counter in place of the matching value.
- R7: With control bit 6 = 0, a channel gives one event and then stays silent until its match or control word is written again. With bit 6 = 1 it gives an event on every match.
- R8: `irq_o` is high exactly while any status bit is set. Writing the status word clears each bit written as 1 and leaves bits written as 0 alone.
- R9: If control bit 9 of channel 9 (or 11) is set, a read of that channel's counter copies the current counter of channel 8 (or 10) into the snapshot word. With bit 9 clear, or on any other channel, the snapshot word is left alone.
- R10: Register map. Counters are at 0x40 + 4·(n−4), match words at 0x80 + 4·(n−4) and control words at 0xC0 + 4·(n−4). The snapshot word is at 0x20, the enable word at 0x24 and the status word at 0x28, with channel n on bit n in both the enable and status words. A write to a counter loads it. Other addresses read 0.
- R11: `bus_rdata` takes its new value on the clock edge that samples `bus_rd` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| rate_stb | input | NSRC | Rate strobes, bit k serving rate code k+1 |
| irq_o | output | 1 | Merged interrupt of channels 4–11 |

## Verification
The hardest case to reach from the ports is a follower channel that takes its match from the group leader while its own counter sits still. It only proves anything when the two counters hold different values. The stimulus preloads the follower's counter with a value the leader never reaches. It then drives only the leader's strobe and checks three things: the follower's status bit, the leader's count, and the follower's unchanged counter. The one-shot mode needs a second trip through the match value. The bench gets there by loading the counter back to 0 with a bus write, which does not re-arm the channel, and then shows that a match-word write does re-arm it.

// File: rtl/mt_pkg.sv
package mt_pkg;
   localparam int NCH      = 8;
   localparam int FIRST_CH = 4;
   localparam int CTRL_W   = 10;

   localparam int B_CLR  = 3;
   localparam int B_PER  = 6;
   localparam int B_OWN  = 7;
   localparam int B_HALT = 8;
   localparam int B_SNAP = 9;

   localparam logic [2:0] G_CNT = 3'b010;
   localparam logic [2:0] G_MAT = 3'b100;
   localparam logic [2:0] G_CTL = 3'b110;
   localparam logic [7:0] A_SNAP = 8'h20;
   localparam logic [7:0] A_IEN  = 8'h24;
   localparam logic [7:0] A_STAT = 8'h28;

   // index 0..7 maps to channel 4..11; returns index of the group leader
   function automatic int leader_of(input int idx);
      if (idx < 4) return 0;
      else if (idx < 6) return 4;
      else return 6;
   endfunction
endpackage

// File: rtl/mt_rate_sel.sv
module mt_rate_sel #(
   parameter int NSRC = 5,
   parameter bit LEAD = 1'b1
) (
   input  logic [2:0]      code,
   input  logic            own,
   input  logic            halt,
   input  logic [NSRC-1:0] stb,
   output logic            adv
);
   logic use_rate;
   assign use_rate = LEAD ? 1'b1 : own;

   always_comb begin
      adv = 1'b0;
      for (int k = 0; k < NSRC; k++) begin
         if (int'(code) == k + 1) adv = stb[k];
      end
      if (!use_rate || halt) adv = 1'b0;
   end
endmodule

// File: rtl/mt_counter.sv
module mt_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         clr,
   input  logic         adv,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= load_val;
      else if (clr)  cnt <= '0;
      else if (adv)  cnt <= cnt + W'(1);
   end
endmodule

// File: rtl/mt_match.sv
module mt_match #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sel_cnt,
   input  logic         sel_adv,
   input  logic         sel_load,
   input  logic [W-1:0] match_val,
   input  logic         rearm,
   input  logic         periodic,
   output logic         hit,
   output logic         armed
);
   assign hit = armed && sel_adv && !sel_load && ((sel_cnt + W'(1)) == match_val);

   always_ff @(posedge clk) begin
      if (!rst_n)                armed <= 1'b1;
      else if (rearm)            armed <= 1'b1;
      else if (hit && !periodic) armed <= 1'b0;
   end
endmodule

// File: rtl/match_timer_bank.sv
module match_timer_bank #(
   parameter int CNT_W   = 32,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8,
   parameter int NSRC    = 5,
   parameter bit SNAP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NSRC-1:0]   rate_stb,
   output logic              irq_o
);
   import mt_pkg::*;

   localparam int BIT_LO = FIRST_CH;
   localparam int BIT_HI = FIRST_CH + NCH - 1;

   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("CNT_W must lie in 2..DATA_W");
   end
   if (DATA_W < BIT_HI + 1) begin : g_bad_data_w
      $error("DATA_W too narrow for status bits");
   end
   if (ADDR_W < 8) begin : g_bad_addr_w
      $error("ADDR_W must be at least 8");
   end
   if (NSRC < 1 || NSRC > 5) begin : g_bad_nsrc
      $error("NSRC must lie in 1..5");
   end

   // decode
   logic       addr_ok;
   logic [2:0] grp;
   logic [2:0] chs;
   assign addr_ok = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 8) == '0);
   assign grp     = bus_addr[7:5];
   assign chs     = bus_addr[4:2];

   logic wr_ien, wr_stat;
   assign wr_ien  = bus_wr && addr_ok && (bus_addr[7:0] == A_IEN);
   assign wr_stat = bus_wr && addr_ok && (bus_addr[7:0] == A_STAT);

   logic [NCH-1:0]     wr_cnt, wr_mat, wr_ctl, rd_cnt;
   logic [NCH-1:0]     adv, hit, clr, rearm, armed;
   logic [CNT_W-1:0]   cnt_q  [NCH];
   logic [CNT_W-1:0]   mat_q  [NCH];
   logic [CTRL_W-1:0]  ctrl_q [NCH];
   logic [NCH-1:0]     ien_q, stat_q, stat_clr;
   logic [CNT_W-1:0]   snap_q;
   logic [DATA_W-1:0]  rd_val;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam int L    = leader_of(i);
      localparam bit LEAD = (L == i);

      logic [CTRL_W-1:0] ctl_r;
      logic [CNT_W-1:0]  mat_r;
      logic              halt;
      logic [CNT_W-1:0]  s_cnt;
      logic              s_adv, s_ld;

      assign wr_cnt[i] = bus_wr && addr_ok && (grp == G_CNT) && (chs == 3'(i));
      assign wr_mat[i] = bus_wr && addr_ok && (grp == G_MAT) && (chs == 3'(i));
      assign wr_ctl[i] = bus_wr && addr_ok && (grp == G_CTL) && (chs == 3'(i));
      assign rd_cnt[i] = bus_rd && addr_ok && (grp == G_CNT) && (chs == 3'(i));
      assign rearm[i]  = wr_mat[i] || wr_ctl[i];

      // control width variant: wide channels keep halt and snapshot bits
      if (i >= 4) begin : g_wide
         always_ff @(posedge clk) begin
            if (!rst_n)         ctl_r <= '0;
            else if (wr_ctl[i]) ctl_r <= bus_wdata[CTRL_W-1:0];
         end
         assign halt = ctl_r[B_HALT];
      end else begin : g_narrow
         always_ff @(posedge clk) begin
            if (!rst_n)         ctl_r <= '0;
            else if (wr_ctl[i]) ctl_r <= {2'b00, bus_wdata[7:0]};
         end
         assign halt = 1'b0;
      end
      assign ctrl_q[i] = ctl_r;

      always_ff @(posedge clk) begin
         if (!rst_n)         mat_r <= '0;
         else if (wr_mat[i]) mat_r <= bus_wdata[CNT_W-1:0];
      end
      assign mat_q[i] = mat_r;

      mt_rate_sel #(.NSRC(NSRC), .LEAD(LEAD)) u_rate (
         .code (ctl_r[2:0]),
         .own  (ctl_r[B_OWN]),
         .halt (halt),
         .stb  (rate_stb),
         .adv  (adv[i])
      );

      mt_counter #(.W(CNT_W)) u_cnt (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (wr_cnt[i]),
         .load_val (bus_wdata[CNT_W-1:0]),
         .clr      (clr[i]),
         .adv      (adv[i]),
         .cnt      (cnt_q[i])
      );

      // pick the counter this channel compares against
      if (LEAD) begin : g_lead
         assign s_cnt = cnt_q[i];
         assign s_adv = adv[i];
         assign s_ld  = wr_cnt[i];
      end else begin : g_follow
         assign s_cnt = ctl_r[B_OWN] ? cnt_q[i]  : cnt_q[L];
         assign s_adv = ctl_r[B_OWN] ? adv[i]    : adv[L];
         assign s_ld  = ctl_r[B_OWN] ? wr_cnt[i] : wr_cnt[L];
      end

      mt_match #(.W(CNT_W)) u_match (
         .clk       (clk),
         .rst_n     (rst_n),
         .sel_cnt   (s_cnt),
         .sel_adv   (s_adv),
         .sel_load  (s_ld),
         .match_val (mat_r),
         .rearm     (rearm[i]),
         .periodic  (ctl_r[B_PER]),
         .hit       (hit[i]),
         .armed     (armed[i])
      );

      assign clr[i] = hit[i] && ctl_r[B_CLR];
   end

   // enable and status
   assign stat_clr = wr_stat ? bus_wdata[BIT_HI:BIT_LO] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien_q  <= '0;
         stat_q <= '0;
      end else begin
         if (wr_ien) ien_q <= bus_wdata[BIT_HI:BIT_LO];
         stat_q <= (stat_q & ~stat_clr) | (hit & ien_q);
      end
   end

   assign irq_o = |stat_q;

   // snapshot of a leader counter on a follower counter read
   if (SNAP_EN) begin : g_snap
      always_ff @(posedge clk) begin
         if (!rst_n)
            snap_q <= '0;
         else if (rd_cnt[5] && ctrl_q[5][B_SNAP])
            snap_q <= cnt_q[4];
         else if (rd_cnt[7] && ctrl_q[7][B_SNAP])
            snap_q <= cnt_q[6];
      end
   end else begin : g_nosnap
      assign snap_q = '0;
   end

   // read path
   always_comb begin
      rd_val = '0;
      if (addr_ok) begin
         if (grp == G_CNT)                   rd_val = DATA_W'(cnt_q[chs]);
         else if (grp == G_MAT)              rd_val = DATA_W'(mat_q[chs]);
         else if (grp == G_CTL)              rd_val = DATA_W'(ctrl_q[chs]);
         else if (bus_addr[7:0] == A_SNAP)   rd_val = DATA_W'(snap_q);
         else if (bus_addr[7:0] == A_IEN)    rd_val = DATA_W'({ien_q, 4'b0000});
         else if (bus_addr[7:0] == A_STAT)   rd_val = DATA_W'({stat_q, 4'b0000});
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_val;
   end
endmodule

// File: rtl/match_timer_bank_chk.sv
module match_timer_bank_chk #(
   parameter int NCH   = 8,
   parameter int CNT_W = 32,
   parameter int NSRC  = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [9:0]       ctrl [NCH],
   input logic [CNT_W-1:0] cnt  [NCH],
   input logic [NCH-1:0]   ld,
   input logic [NCH-1:0]   clr,
   input logic [NCH-1:0]   hit,
   input logic [NCH-1:0]   rearm,
   input logic [NCH-1:0]   armed,
   input logic [NCH-1:0]   stat,
   input logic [NCH-1:0]   ien,
   input logic [NCH-1:0]   stat_clr
);
   for (genvar i = 0; i < NCH; i++) begin : g_a
      // R2: a counter only holds or steps by one unless loaded or cleared
      assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (!ld[i] && !clr[i]) |=> (cnt[i] == $past(cnt[i]) || cnt[i] == $past(cnt[i]) + CNT_W'(1)));

      // R2: stopped rate codes hold the counter
      assert_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
         ((ctrl[i][2:0] == 3'd0 || int'(ctrl[i][2:0]) > NSRC) && !ld[i] && !clr[i]) |=> $stable(cnt[i]));

      // R6: auto-clear leaves zero
      assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !ld[i]) |=> (cnt[i] == '0));

      // R7: one-shot channel disarms after its event
      assert_oneshot_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (hit[i] && !ctrl[i][6] && !rearm[i]) |=> !armed[i]);

      // R5: status rises only with enable
      assert_status_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(stat[i]) |-> $past(ien[i]));

      // R8: status falls only by a write of one
      assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(stat[i]) |-> $past(stat_clr[i]));

      if (i != 0 && i != 4 && i != 6) begin : g_follow
         // R3: a follower in shared mode keeps its own counter still
         assert_shared_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl[i][7] && !ld[i] && !clr[i]) |=> $stable(cnt[i]));
      end
      if (i >= 4) begin : g_wide
         // R4: halt bit holds the counter
         assert_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl[i][8] && !ld[i] && !clr[i]) |=> $stable(cnt[i]));
      end
   end
endmodule

bind match_timer_bank match_timer_bank_chk #(
   .NCH   (mt_pkg::NCH),
   .CNT_W (CNT_W),
   .NSRC  (NSRC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctrl     (ctrl_q),
   .cnt      (cnt_q),
   .ld       (wr_cnt),
   .clr      (clr),
   .hit      (hit),
   .rearm    (rearm),
   .armed    (armed),
   .stat     (stat_q),
   .ien      (ien_q),
   .stat_clr (stat_clr)
);

// File: tb/match_timer_bank_bench.sv
module match_timer_bank_bench;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n;
   logic        bus_wr, bus_rd;
   logic [7:0]  bus_addr;
   logic [31:0] bus_wdata;
   wire  [31:0] bus_rdata;
   logic [4:0]  rate_stb;
   wire         irq_o;

   int total = 0;
   int fails = 0;

   match_timer_bank u_match_timer_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .rate_stb  (rate_stb),
      .irq_o     (irq_o)
   );

   localparam logic [7:0] SNAP = 8'h20;
   localparam logic [7:0] IEN  = 8'h24;
   localparam logic [7:0] STAT = 8'h28;

   function automatic logic [7:0] a_cnt(input int c); return 8'(8'h40 + 4 * (c - 4)); endfunction
   function automatic logic [7:0] a_mat(input int c); return 8'(8'h80 + 4 * (c - 4)); endfunction
   function automatic logic [7:0] a_ctl(input int c); return 8'(8'hC0 + 4 * (c - 4)); endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // every task starts and ends just after a falling edge
   task automatic do_reset();
      rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
      bus_addr = '0; bus_wdata = '0; rate_stb = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic pulse(input int k, input int n);
      for (int j = 0; j < n; j++) begin
         rate_stb = 5'(1 << k);
         @(negedge clk);
         rate_stb = '0;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      logic [31:0] v;
      rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
      bus_addr = '0; bus_wdata = '0; rate_stb = '0;

      // R1 reset state
      do_reset();
      check("R1 irq", {31'b0, irq_o}, 32'h0);
      for (int c = 4; c < 12; c++) begin
         rd(a_cnt(c), v); check("R1 cnt", v, 0);
         rd(a_mat(c), v); check("R1 mat", v, 0);
         rd(a_ctl(c), v); check("R1 ctl", v, 0);
      end
      rd(SNAP, v); check("R1 snap", v, 0);
      rd(IEN, v);  check("R1 ien", v, 0);
      rd(STAT, v); check("R1 stat", v, 0);
      for (int k = 0; k < 5; k++) pulse(k, 2);
      rd(a_cnt(4), v); check("R1 stopped", v, 0);
      rd(a_cnt(8), v); check("R1 stopped", v, 0);

      // R10 map and counter load
      for (int c = 4; c < 12; c++) begin
         wr(a_mat(c), 32'hC0DE_0000 | 32'(c));
         wr(a_cnt(c), 32'h0100_0000 + 32'(c));
      end
      wr(8'h3C, 32'hFFFF_FFFF);
      wr(8'h60, 32'hFFFF_FFFF);
      for (int c = 4; c < 12; c++) begin
         rd(a_mat(c), v); check("R10 mat", v, 32'hC0DE_0000 | 32'(c));
         rd(a_cnt(c), v); check("R10 cnt", v, 32'h0100_0000 + 32'(c));
      end
      rd(8'h3C, v); check("R10 unmapped", v, 0);
      rd(8'h60, v); check("R10 unmapped", v, 0);

      // R4 control widths
      do_reset();
      for (int c = 4; c < 12; c++) wr(a_ctl(c), 32'hFFFF_FFF8);
      for (int c = 4; c < 12; c++) begin
         rd(a_ctl(c), v); check("R4 width", v, (c < 8) ? 32'hF8 : 32'h3F8);
      end

      // R2 rate sweep: strobe k pulsed k+1 times
      do_reset();
      for (int c = 4; c < 12; c++) begin
         for (int code = 0; code < 8; code++) begin
            wr(a_ctl(c), 32'h80 | 32'(code));
            wr(a_cnt(c), 0);
            for (int k = 0; k < 5; k++) pulse(k, k + 1);
            rd(a_cnt(c), v);
            check("R2 rate", v, (code >= 1 && code <= 5) ? 32'(code) : 32'h0);
            wr(a_ctl(c), 0);
         end
      end

      // R3 sharing, then own mode
      for (int p = 0; p < 5; p++) begin
         int f, l;
         f = (p < 3) ? 5 + p : (p == 3 ? 9 : 11);
         l = (f < 8) ? 4 : f - 1;
         do_reset();
         wr(a_ctl(l), 1);
         wr(a_ctl(f), 1);
         wr(a_cnt(f), 77);
         wr(a_mat(f), 3);
         wr(IEN, 32'(1 << f));
         pulse(0, 2);
         rd(STAT, v); check("R3 shared early", v, 0);
         pulse(0, 1);
         rd(STAT, v);     check("R3 shared hit", v, 32'(1 << f));
         rd(a_cnt(l), v); check("R3 leader cnt", v, 3);
         rd(a_cnt(f), v); check("R3 follower hold", v, 77);
         wr(a_ctl(f), 32'h82);
         wr(a_cnt(f), 0);
         wr(a_mat(f), 2);
         wr(STAT, 32'hFF0);
         pulse(0, 2);
         rd(STAT, v); check("R3 own ignores leader", v, 0);
         pulse(1, 2);
         rd(a_cnt(f), v); check("R3 own cnt", v, 2);
         rd(STAT, v);     check("R3 own hit", v, 32'(1 << f));
      end

      // R4 halt bit
      do_reset();
      wr(a_ctl(8), 32'h101);
      wr(a_ctl(9), 32'h181);
      wr(a_ctl(4), 32'h101);
      pulse(0, 2);
      rd(a_cnt(8), v); check("R4 halt leader", v, 0);
      rd(a_cnt(9), v); check("R4 halt own", v, 0);
      rd(a_cnt(4), v); check("R4 narrow ignores bit8", v, 2);

      // R5 enable gating and match cycle
      do_reset();
      wr(a_ctl(4), 1);
      wr(a_mat(4), 2);
      pulse(0, 2);
      rd(STAT, v); check("R5 no enable", v, 0);
      check("R5 irq low", {31'b0, irq_o}, 0);
      wr(a_ctl(10), 1);
      wr(a_mat(10), 3);
      wr(IEN, 32'h400);
      pulse(0, 2);
      rd(STAT, v); check("R5 before match", v, 0);
      pulse(0, 1);
      rd(STAT, v); check("R5 at match", v, 32'h400);

      // R6 auto-clear with periodic mode
      do_reset();
      wr(a_ctl(8), 32'h49);
      wr(a_mat(8), 3);
      wr(IEN, 32'h100);
      pulse(0, 3);
      rd(a_cnt(8), v); check("R6 cleared", v, 0);
      rd(STAT, v);     check("R6 event", v, 32'h100);
      wr(STAT, 32'h100);
      rd(STAT, v);     check("R8 cleared", v, 0);
      pulse(0, 3);
      rd(STAT, v);     check("R7 periodic again", v, 32'h100);
      rd(a_cnt(8), v); check("R6 cleared again", v, 0);

      // R7 one-shot
      do_reset();
      wr(a_ctl(5), 32'h81);
      wr(a_mat(5), 2);
      wr(IEN, 32'h20);
      pulse(0, 2);
      rd(a_cnt(5), v); check("R6 no clear", v, 2);
      rd(STAT, v);     check("R7 first event", v, 32'h20);
      wr(STAT, 32'h20);
      wr(a_cnt(5), 0);
      pulse(0, 2);
      rd(STAT, v);     check("R7 one-shot silent", v, 0);
      wr(a_mat(5), 2);
      wr(a_cnt(5), 0);
      pulse(0, 2);
      rd(STAT, v);     check("R7 rearmed", v, 32'h20);

      // R8 merged interrupt
      do_reset();
      wr(a_ctl(4), 1);
      wr(a_mat(4), 1);
      wr(a_ctl(6), 32'h81);
      wr(a_mat(6), 1);
      wr(IEN, 32'h50);
      pulse(0, 1);
      rd(STAT, v); check("R8 both set", v, 32'h50);
      check("R8 irq high", {31'b0, irq_o}, 1);
      wr(STAT, 0);
      check("R8 zero write", {31'b0, irq_o}, 1);
      wr(STAT, 32'h10);
      rd(STAT, v); check("R8 partial", v, 32'h40);
      check("R8 irq stays", {31'b0, irq_o}, 1);
      wr(STAT, 32'h40);
      check("R8 irq low", {31'b0, irq_o}, 0);
      rd(IEN, v); check("R10 ien", v, 32'h50);

      // R9 snapshot
      do_reset();
      wr(a_ctl(8), 32'h81);
      wr(a_cnt(8), 32'h1234);
      pulse(0, 3);
      wr(a_ctl(9), 32'h200);
      rd(a_cnt(9), v); check("R9 own read", v, 0);
      rd(SNAP, v);     check("R9 snap 8", v, 32'h1237);
      pulse(0, 1);
      check("R11 rdata holds", bus_rdata, 32'h1237);
      wr(a_ctl(9), 0);
      rd(a_cnt(9), v);
      rd(SNAP, v);     check("R9 snap off", v, 32'h1237);
      wr(a_ctl(10), 2);
      wr(a_cnt(10), 32'h55);
      pulse(1, 1);
      wr(a_ctl(11), 32'h200);
      rd(a_cnt(11), v);
      rd(SNAP, v);     check("R9 snap 10", v, 32'h56);
      wr(a_ctl(5), 32'h200);
      wr(a_cnt(4), 32'h99);
      rd(a_cnt(5), v);
      rd(SNAP, v);     check("R9 narrow no snap", v, 32'h56);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule